// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block buffers 18-bit words between two unrelated clock domains. A producer pushes words on its own clock with a write enable. A consumer pulls words on a second clock with a read enable. Each side sees the status that matters to it. The write side gets full, half-full and almost-full. The read side gets empty and almost-empty. Each pointer is passed to the opposite domain as a Gray code through a two-stage synchronizer. The storage is an inferred register array whose depth is a parameter: 512, 1024 or 2048 words.

A configuration register is loaded from the write data bus by a separate load strobe on the write clock. It holds three things:
- one threshold used by both the almost-full and almost-empty flags;
- a parity enable;
- a parity mode bit.

In generate mode, bits 8 and 17 of each stored word are replaced with even parity over the byte beneath them. In check mode, words are stored unchanged, and every word read out raises a per-byte error flag when its 9-bit half has odd parity.

A retransmit strobe on the read clock rewinds the read pointer to location zero, so that a block written once can be replayed. One active-low master reset, asserted asynchronously and released synchronously in each domain, returns the block to its initial state.

Top module: `pflag_fifo`

## Requirements
- R1: Words leave in the order they were written, and with parity disabled all 18 bits arrive unchanged.
- R2: `empty` is high whenever the read domain sees zero stored words. A read request while `empty` is high changes neither `rd_data` nor the read pointer.
- R3: `full` is high once DEPTH words are stored. A write request while `full` is high is dropped, and the write pointer does not move.
- R4: `half_full` is high exactly when the write-side word count is greater than DEPTH/2.
- R5: `almost_full` is high when the free space (DEPTH minus the write-side count) is at or below the programmed threshold.
- R6: `almost_empty` is high when the read-side word count is at or below the programmed threshold.
- R7: On a write-clock edge, `cfg_we` high loads `wr_data` into the configuration register. The fields are: bits 10:0 threshold, bit 16 parity enable, bit 17 mode (1 = check, 0 = generate). That word is not stored in the FIFO, and `wr_en` in the same cycle is ignored. After reset the threshold is 8 and parity is disabled.
- R8: With parity enabled in generate mode, the stored bit 8 equals the XOR of bits 7:0. The stored bit 17 equals the XOR of bits 16:9.
- R9: With parity enabled in check mode, each accepted read sets `par_err[0]` to the XOR of bits 8:0 and `par_err[1]` to the XOR of bits 17:9 of the word read. Any read accepted with check mode off clears `par_err`.
- R10: `retx` high on a read-clock edge sets the read pointer to location zero, and a read requested in that same cycle is ignored. The rewind is meaningful while no more than DEPTH words have been written since reset.
- R11: While `rst_n` is low, both pointers are zero and the outputs read as follows: `empty` and `almost_empty` are 1; `full`, `half_full`, `almost_full`, `par_err` and `rd_data` are 0.
- R12: `rd_data` is registered. It takes the next word on the read-clock edge that accepts a read and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Master reset, active low, asynchronous assertion |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request |
| cfg_we | input | 1 | Load configuration register from `wr_data` |
| wr_data | input | 18 | Write data / configuration word |
| full | output | 1 | FIFO full (write domain) |
| half_full | output | 1 | More than DEPTH/2 words stored (write domain) |
| almost_full | output | 1 | Free space at or below threshold (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit: rewind read pointer to zero |
| rd_data | output | 18 | Registered read data |
| empty | output | 1 | FIFO empty (read domain) |
| almost_empty | output | 1 | Stored count at or below threshold (read domain) |
| par_err | output | 2 | Parity error of last word read, per 9-bit half |

## Verification
Retransmit and read can both be requested on the same read-clock edge, and the design must let the rewind win. The bench raises `rd_en` and `retx` together after two words have been consumed. It then confirms two things: `rd_data` still holds the second word, and the following reads replay the whole block from the first word until `empty` rises. A second collision, a configuration load that arrives with a write request, is judged by showing the FIFO drains to empty without ever returning the configuration word.

// File: rtl/pff_pkg.sv
package pff_pkg;
  localparam int DW    = 18;  // word width
  localparam int OFF_W = 11;  // threshold field width
  localparam int CW    = 12;  // count width, covers the deepest option

  typedef struct packed {
    logic             chk;     // 1: check parity on read, 0: generate on write
    logic             par_en;  // parity function enabled
    logic [OFF_W-1:0] off;     // almost-full / almost-empty threshold
  } cfg_t;
endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pff_ram.sv
module pff_ram import pff_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic                     wclk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side import pff_pkg::*; #(
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     cfg_we,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH):0]   rd_gray_s,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic [DW-1:0]            mem_wdata,
  output logic [$clog2(DEPTH):0]   wr_gray,
  output logic                     full,
  output logic                     half_full,
  output logic                     almost_full,
  output cfg_t                     cfg
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;

  logic [AW:0]   wbin_q, wbin_nx, wgray_q, wgray_nx, rbin_s, wcnt;
  logic [CW-1:0] used, space;
  logic          accept;
  cfg_t          cfg_q, cfg_nx;

  // Gray to binary for the synchronized read pointer
  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rd_gray_s >> i);
  end

  always_comb begin
    wcnt        = wbin_q - rbin_s;
    used        = CW'(wcnt);
    space       = CW'(DEPTH) - used;
    full        = (used == CW'(DEPTH));
    half_full   = (used > CW'(HALF));
    almost_full = (space <= {1'b0, cfg_q.off});
    accept      = wr_en && !cfg_we && !full;
    wbin_nx     = wbin_q + (AW+1)'(accept);
    wgray_nx    = wbin_nx ^ (wbin_nx >> 1);
    cfg_nx      = cfg_q;
    if (cfg_we) begin
      cfg_nx.chk    = wr_data[17];
      cfg_nx.par_en = wr_data[16];
      cfg_nx.off    = wr_data[OFF_W-1:0];
    end
    mem_wdata = wr_data;
    if (cfg_q.par_en && !cfg_q.chk) begin
      mem_wdata[8]  = ^wr_data[7:0];
      mem_wdata[17] = ^wr_data[16:9];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      cfg_q   <= '{chk: 1'b0, par_en: 1'b0, off: OFF_W'(DEF_OFF)};
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wgray_nx;
      cfg_q   <= cfg_nx;
    end
  end

  assign mem_we   = accept;
  assign mem_addr = wbin_q[AW-1:0];
  assign wr_gray  = wgray_q;
  assign cfg      = cfg_q;
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side import pff_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     retx,
  input  logic [$clog2(DEPTH):0]   wr_gray_s,
  input  logic [OFF_W-1:0]         off,
  input  logic                     chk_en,
  input  logic [DW-1:0]            mem_rdata,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic [$clog2(DEPTH):0]   rd_gray,
  output logic                     empty,
  output logic                     almost_empty,
  output logic [DW-1:0]            rd_data,
  output logic [1:0]               par_err
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]   rbin_q, rbin_nx, rgray_q, rgray_nx, wbin_s, rcnt;
  logic [DW-1:0] dout_q, dout_nx;
  logic [1:0]    perr_q, perr_nx;
  logic          accept;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wr_gray_s >> i);
  end

  always_comb begin
    rcnt         = wbin_s - rbin_q;
    empty        = (rcnt == '0);
    almost_empty = (CW'(rcnt) <= {1'b0, off});
    accept       = rd_en && !retx && !empty;
    if (retx) rbin_nx = '0;
    else      rbin_nx = rbin_q + (AW+1)'(accept);
    rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    dout_nx  = dout_q;
    perr_nx  = perr_q;
    if (accept) begin
      dout_nx = mem_rdata;
      perr_nx = chk_en ? {^mem_rdata[17:9], ^mem_rdata[8:0]} : 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      perr_q  <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rgray_nx;
      dout_q  <= dout_nx;
      perr_q  <= perr_nx;
    end
  end

  assign mem_addr = rbin_q[AW-1:0];
  assign rd_gray  = rgray_q;
  assign rd_data  = dout_q;
  assign par_err  = perr_q;
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo import pff_pkg::*; #(
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 8
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic          cfg_we,
  input  logic [17:0]   wr_data,
  output logic          full,
  output logic          half_full,
  output logic          almost_full,
  input  logic          rd_clk,
  input  logic          rd_en,
  input  logic          retx,
  output logic [17:0]   rd_data,
  output logic          empty,
  output logic          almost_empty,
  output logic [1:0]    par_err
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_rst_n, rd_rst_n;
  logic [AW:0]   wr_gray_w, rd_gray_w, wr_gray_s, rd_gray_s;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  cfg_t          cfg_w;
  logic          chk_en;

  assign chk_en = cfg_w.par_en & cfg_w.chk;

  // per-domain reset: asserted at once, released after two local edges
  gray_sync #(.W(1)) u_wr_rst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n));
  gray_sync #(.W(1)) u_rd_rst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n));

  gray_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray_w), .q(wr_gray_s));
  gray_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray_w), .q(rd_gray_s));

  pff_wr_side #(.DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .cfg_we(cfg_we),
    .wr_data(wr_data), .rd_gray_s(rd_gray_s), .mem_we(mem_we),
    .mem_addr(mem_waddr), .mem_wdata(mem_wdata), .wr_gray(wr_gray_w),
    .full(full), .half_full(half_full), .almost_full(almost_full), .cfg(cfg_w)
  );

  pff_ram #(.DEPTH(DEPTH)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  pff_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .retx(retx),
    .wr_gray_s(wr_gray_s), .off(cfg_w.off), .chk_en(chk_en),
    .mem_rdata(mem_rdata), .mem_addr(mem_raddr), .rd_gray(rd_gray_w),
    .empty(empty), .almost_empty(almost_empty), .rd_data(rd_data),
    .par_err(par_err)
  );
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
  parameter int GW = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic          wr_en,
  input logic          cfg_we,
  input logic          rd_en,
  input logic          retx,
  input logic          full,
  input logic          half_full,
  input logic          almost_full,
  input logic          empty,
  input logic          chk_en,
  input logic [GW-1:0] wr_gray,
  input logic [GW-1:0] rd_gray,
  input logic [17:0]   rd_data,
  input logic [1:0]    par_err
);
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (full && wr_en && !cfg_we) |=> $stable(wr_gray));

  assert_empty_read_ignored_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (empty && rd_en && !retx) |=> ($stable(rd_data) && $stable(rd_gray)));

  assert_wr_gray_one_step_R1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

  assert_full_implies_half_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |-> half_full);

  assert_full_implies_afull_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |-> almost_full);

  assert_retx_rewinds_R10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    retx |=> (rd_gray == '0));

  assert_perr_clear_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && !retx && !empty && !chk_en) |=> (par_err == 2'b00));

  assert_cfg_no_store_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    cfg_we |=> $stable(wr_gray));
endmodule

bind pflag_fifo pflag_fifo_chk #(.GW(AW+1)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_en(wr_en), .cfg_we(cfg_we), .rd_en(rd_en), .retx(retx),
  .full(full), .half_full(half_full), .almost_full(almost_full),
  .empty(empty), .chk_en(chk_en), .wr_gray(wr_gray_w), .rd_gray(rd_gray_w),
  .rd_data(rd_data), .par_err(par_err)
);

// File: tb/pflag_fifo_bench.sv
module pflag_fifo_bench;
  localparam int DEPTH = 512;
  localparam int OFF0  = 8;

  logic        rst_n, wr_clk, wr_en, cfg_we, rd_clk, rd_en, retx;
  logic [17:0] wr_data, rd_data;
  logic        full, half_full, almost_full, empty, almost_empty;
  logic [1:0]  par_err;

  int checks = 0;
  int errors = 0;

  // {input word, word read back in generate mode}
  localparam logic [35:0] VEC [8] = '{
    {18'h00000, 18'h00000},
    {18'h00001, 18'h00101},
    {18'h00003, 18'h00003},
    {18'h00100, 18'h00000},
    {18'h00200, 18'h20200},
    {18'h3FFFF, 18'h1FEFF},
    {18'h0FE07, 18'h2FF07},
    {18'h10055, 18'h30055}
  };

  pflag_fifo #(.DEPTH(DEPTH), .DEF_OFF(OFF0)) u_pflag_fifo (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .cfg_we(cfg_we),
    .wr_data(wr_data), .full(full), .half_full(half_full),
    .almost_full(almost_full), .rd_clk(rd_clk), .rd_en(rd_en), .retx(retx),
    .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
    .par_err(par_err)
  );

  initial wr_clk = 0;
  always #5 wr_clk = ~wr_clk;
  initial begin
    rd_clk = 0;
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 0; wr_en = 0; cfg_we = 0; rd_en = 0; retx = 0; wr_data = '0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1;
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic push(logic [17:0] d);
    @(negedge wr_clk); wr_en = 1; wr_data = d;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic load_cfg(logic [17:0] d);
    @(negedge wr_clk); cfg_we = 1; wr_en = 1; wr_data = d;
    @(negedge wr_clk); cfg_we = 0; wr_en = 0;
  endtask

  task automatic pop(output logic [17:0] d);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [17:0] d, hold;
    int bad;

    // R11: state while reset is held
    rst_n = 0; wr_en = 0; cfg_we = 0; rd_en = 0; retx = 0; wr_data = '0;
    repeat (3) @(negedge wr_clk);
    check("R11 empty", 32'(empty), 1);
    check("R11 almost_empty", 32'(almost_empty), 1);
    check("R11 full/half/afull", {29'b0, full, half_full, almost_full}, 0);
    check("R11 rd_data/par_err", {12'b0, par_err, rd_data}, 0);
    rst_n = 1;
    repeat (6) @(negedge wr_clk);

    // R1/R12: table walk with parity off, then R8 with generate mode
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) load_cfg(18'h10000 | 18'(OFF0));
      for (int i = 0; i < 8; i++) push(VEC[i][35:18]);
      settle();
      for (int i = 0; i < 8; i++) begin
        pop(d);
        check(pass == 0 ? "R1 order/data" : "R8 parity generate",
              32'(d), pass == 0 ? 32'(VEC[i][35:18]) : 32'(VEC[i][17:0]));
      end
      check("R7 config word not stored (empty after drain)", 32'(empty), 1);
    end
    hold = rd_data;
    repeat (4) @(negedge rd_clk);
    check("R12 rd_data held without read", 32'(rd_data), 32'(hold));

    // R2: read while empty is ignored
    pop(d);
    check("R2 rd_data unchanged on empty read", 32'(d), 32'(hold));
    load_cfg(18'(OFF0));
    push(18'h01234);
    settle();
    pop(d);
    check("R2 pointer not advanced by empty read", 32'(d), 32'h01234);

    // R9: check mode
    load_cfg(18'h30000 | 18'(OFF0));
    push(18'h00101); push(18'h00001); push(18'h00200); push(18'h20200);
    settle();
    pop(d); check("R9 good word err", 32'(par_err), 0);
    pop(d); check("R9 low half error", 32'(par_err), 1);
    check("R9 word passes unchanged in check mode", 32'(d), 32'h00001);
    pop(d); check("R9 high half error", 32'(par_err), 2);
    pop(d); check("R9 good high half", 32'(par_err), 0);
    load_cfg(18'(OFF0));
    push(18'h00001);
    settle();
    pop(d); check("R9 err clear with check off", 32'(par_err), 0);

    // R6/R7: almost-empty against threshold
    for (int i = 0; i < 9; i++) push(18'(i));
    settle();
    check("R6 9 words above threshold 8", 32'(almost_empty), 0);
    pop(d);
    check("R6 8 words at threshold 8", 32'(almost_empty), 1);
    load_cfg(18'h00003);
    settle();
    check("R7 new threshold 3, 8 words", 32'(almost_empty), 0);
    for (int i = 0; i < 4; i++) pop(d);
    check("R6 4 words above threshold 3", 32'(almost_empty), 0);
    pop(d);
    check("R6 3 words at threshold 3", 32'(almost_empty), 1);
    for (int i = 0; i < 3; i++) pop(d);
    check("R2 empty after drain", 32'(empty), 1);

    // R3/R4/R5: fill to full
    reset_dut();
    for (int i = 0; i < DEPTH; i++) begin
      push(18'(i));
      if (i + 1 == DEPTH / 2)     check("R4 half_full at DEPTH/2", 32'(half_full), 0);
      if (i + 1 == DEPTH / 2 + 1) check("R4 half_full above DEPTH/2", 32'(half_full), 1);
      if (i + 1 == DEPTH - OFF0 - 1) check("R5 afull free=9", 32'(almost_full), 0);
      if (i + 1 == DEPTH - OFF0)     check("R5 afull free=8", 32'(almost_full), 1);
      if (i + 1 == DEPTH - 1)        check("R3 not full at DEPTH-1", 32'(full), 0);
    end
    check("R3 full at DEPTH", 32'(full), 1);
    push(18'h3ABCD);
    settle();
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      if (d !== 18'(i)) bad++;
    end
    check("R3 all words intact after write while full", 32'(bad), 0);
    check("R3 extra write dropped (empty)", 32'(empty), 1);

    // R11: asynchronous reset mid-run
    push(18'h00011); push(18'h00022); push(18'h00033);
    settle();
    #2 rst_n = 0;
    #1;
    check("R11 async reset empty", 32'(empty), 1);
    check("R11 async reset rd_data", 32'(rd_data), 0);
    repeat (2) @(negedge wr_clk);
    rst_n = 1;
    repeat (6) @(negedge wr_clk);

    // R10: retransmit colliding with a read
    push(18'h00011); push(18'h00022); push(18'h00033); push(18'h00044);
    settle();
    pop(d); pop(d);
    check("R10 second word before rewind", 32'(d), 32'h00022);
    @(negedge rd_clk); rd_en = 1; retx = 1;
    @(negedge rd_clk); rd_en = 0; retx = 0;
    check("R10 read ignored with retx", 32'(rd_data), 32'h00022);
    for (int i = 0; i < 4; i++) begin
      pop(d);
      check("R10 replay from first word", 32'(d), 32'h11 * (i + 1));
    end
    check("R10 empty after replay", 32'(empty), 1);

    finish_run();
  end
endmodule